// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Register Port

This block is the digital host port of a four-channel, 12-bit converter. Each channel keeps a conversion code and a two-bit mode setting. Both are held in two ranks. Host writes land in the first (staging) rank. The second (live) rank drives the converter and changes only when the host asks for it. The host can ask when it writes, for the targeted channel only. It can also ask later with one transfer strobe that moves every staged value of every channel at the same edge.

A write goes to one channel or to all four at once. A code write can replace the whole 12-bit word, or only a nibble or a byte of it. A single transparent line makes the input data flow into both code ranks of the targeted channels on every clock, with no separate load or update steps. This suits a successive-approximation loop or an end-point calibration. Any register of any rank can be read back combinationally. A synchronous clear input zeroes every register in both ranks.

Top module: `qdac_regport`

## Requirements
- R1: There are four channels. The live code of channel i appears on `code_o[12*i +: 12]`, and the live mode of channel i appears on `mode_o[2*i +: 2]`.
- R2: A mode write (`wr_kind`=1) stores `wr_data[1:0]`, where bit 0 is gain (0 = x1, 1 = x2) and bit 1 is range (0 = unipolar, 1 = bipolar). It leaves both code ranks of that channel unchanged.
- R3: A write (`wr_en`=1) targets channel `wr_ch`, or all four channels when `wr_all`=1. It changes only the staging rank of the written kind, and the live outputs keep their values.
- R4: A write with `upd_now`=1 also loads the new value into the live rank of the written kind, for the targeted channels only, at the same clock edge.
- R5: `xfer`=1 copies the staging code and mode of every channel into the live ranks. The copy includes any write made in the same cycle.
- R6: When `transp`=1, each targeted channel loads `wr_data` into both of its code ranks on every clock, whatever `wr_en` is. For that channel, transparent loading takes precedence over a write.
- R7: `rd_data` shows the register of channel `rd_ch`, selected by `rd_kind` (0 = code, 1 = mode, the mode value zero-extended) and by `rd_rank` (0 = staging, 1 = live), in the same cycle.
- R8: A code write with `byte_mode`=0 selects its field with `part_sel`: 00 puts `wr_data[3:0]` into bits 3:0, 01 puts it into bits 7:4, 10 puts it into bits 11:8, and 11 writes the full `wr_data[11:0]`. The other bits keep their values.
- R9: A code write with `byte_mode`=1 selects its field as follows. `part_sel` 00 puts `wr_data[7:0]` into bits 7:0, 01 puts `wr_data[7:0]` into bits 11:4, 10 puts `wr_data[3:0]` into bits 11:8, and 11 writes the full word.
- R10: `srst`=1 clears the code and mode registers of both ranks of all channels at the next clock edge. It takes precedence over every other input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous clear of all registers, active high |
| wr_en | input | 1 | Write strobe |
| wr_all | input | 1 | Write or transparent-load all channels |
| wr_ch | input | 2 | Target channel |
| wr_kind | input | 1 | 0 = code, 1 = mode |
| part_sel | input | 2 | Field select for code writes |
| byte_mode | input | 1 | Byte-wide partial code writes |
| wr_data | input | 12 | Write data |
| upd_now | input | 1 | Also load the live rank of written channels |
| xfer | input | 1 | Copy all staging registers to live |
| transp | input | 1 | Transparent code load of targeted channels |
| rd_ch | input | 2 | Readback channel |
| rd_kind | input | 1 | Readback kind, 0 = code, 1 = mode |
| rd_rank | input | 1 | Readback rank, 0 = staging, 1 = live |
| rd_data | output | 12 | Readback value |
| code_o | output | 48 | Live codes, channel 0 in the low bits |
| mode_o | output | 8 | Live modes, channel 0 in the low bits |

## Verification
The channel properties take for granted that `srst` is high from time zero through the first clock edge. They also assume that every control input is a known 0 or 1 at each rising edge. The hold property assumes that a live rank moves only on an update, a transfer or a transparent load, so the stimulus changes inputs only away from the rising edge and holds them there for a whole cycle. Each vector sets every control explicitly. Writes to unused fields are never left floating, and a clear pulse is always a single full cycle.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int CODE_W  = 12;
    localparam int MODE_W  = 2;
    localparam int NIB_W   = 4;
    localparam int NUM_NIB = CODE_W / NIB_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [MODE_W-1:0] mode_t;

    typedef struct packed {
        code_t code1;
        code_t code2;
        mode_t mode1;
        mode_t mode2;
    } chan_st_t;
endpackage

// File: rtl/qdac_merge.sv
module qdac_merge
    import qdac_pkg::*;
(
    input  code_t      old_i,
    input  code_t      din_i,
    input  logic [1:0] part_i,
    input  logic       byte_i,
    output code_t      new_o
);
    always_comb begin
        new_o = old_i;
        if (part_i == 2'b11) begin
            new_o = din_i;
        end else if (!byte_i) begin
            for (int k = 0; k < NUM_NIB; k++) begin
                if (part_i == k[1:0]) new_o[k*NIB_W +: NIB_W] = din_i[NIB_W-1:0];
            end
        end else begin
            case (part_i)
                2'b00:   new_o[7:0]  = din_i[7:0];
                2'b01:   new_o[11:4] = din_i[7:0];
                default: new_o[11:8] = din_i[3:0];
            endcase
        end
    end
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
    import qdac_pkg::*;
(
    input  logic       clk,
    input  logic       srst,
    input  logic       sel_i,
    input  logic       wr_i,
    input  logic       kind_i,
    input  logic [1:0] part_i,
    input  logic       byte_i,
    input  code_t      din_i,
    input  logic       upd_i,
    input  logic       xfer_i,
    input  logic       transp_i,
    output code_t      code1_o,
    output code_t      code2_o,
    output mode_t      mode1_o,
    output mode_t      mode2_o
);
    chan_st_t st_d, st_q;
    code_t    merged;
    logic     clr_seen_q;

    qdac_merge u_merge (
        .old_i  (st_q.code1),
        .din_i  (din_i),
        .part_i (part_i),
        .byte_i (byte_i),
        .new_o  (merged)
    );

    always_comb begin
        st_d = st_q;
        if (srst) begin
            st_d = '0;
        end else begin
            if (sel_i && transp_i) begin
                st_d.code1 = din_i;
                st_d.code2 = din_i;
            end else if (sel_i && wr_i) begin
                if (!kind_i) begin
                    st_d.code1 = merged;
                    if (upd_i) st_d.code2 = merged;
                end else begin
                    st_d.mode1 = din_i[MODE_W-1:0];
                    if (upd_i) st_d.mode2 = din_i[MODE_W-1:0];
                end
            end
            if (xfer_i) begin
                st_d.code2 = st_d.code1;
                st_d.mode2 = st_d.mode1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q       <= st_d;
        clr_seen_q <= srst;
    end

    assign code1_o = st_q.code1;
    assign code2_o = st_q.code2;
    assign mode1_o = st_q.mode1;
    assign mode2_o = st_q.mode2;

    // R10: one cycle after a clear, every register reads zero
    a_r10_clear_all: assert property (@(posedge clk) disable iff (srst)
        clr_seen_q |-> (st_q == '0));

    // R3: without update, transfer or transparent load the live code holds
    a_r3_live_holds: assert property (@(posedge clk) disable iff (srst)
        (!xfer_i && !(sel_i && (transp_i || (wr_i && upd_i))))
        |=> $stable(st_q.code2) && $stable(st_q.mode2));

    // R5: after a transfer both ranks agree
    a_r5_xfer_equal: assert property (@(posedge clk) disable iff (srst)
        xfer_i |=> (st_q.code2 == st_q.code1) && (st_q.mode2 == st_q.mode1));

    // R6: transparent load lands in both code ranks
    a_r6_transp_thru: assert property (@(posedge clk) disable iff (srst)
        (sel_i && transp_i) |=> (st_q.code1 == $past(din_i)) && (st_q.code2 == $past(din_i)));

    // R2: a mode write leaves the staging code untouched
    a_r2_mode_keeps_code: assert property (@(posedge clk) disable iff (srst)
        (sel_i && wr_i && kind_i && !transp_i) |=> $stable(st_q.code1));
endmodule

// File: rtl/qdac_rdmux.sv
module qdac_rdmux
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  code_t            code1_i [NUM_CH],
    input  code_t            code2_i [NUM_CH],
    input  mode_t            mode1_i [NUM_CH],
    input  mode_t            mode2_i [NUM_CH],
    input  logic [CH_W-1:0]  ch_i,
    input  logic             kind_i,
    input  logic             rank_i,
    output code_t            data_o
);
    always_comb begin
        data_o = '0;
        case ({kind_i, rank_i})
            2'b00: data_o = code1_i[ch_i];
            2'b01: data_o = code2_i[ch_i];
            2'b10: data_o[MODE_W-1:0] = mode1_i[ch_i];
            default: data_o[MODE_W-1:0] = mode2_i[ch_i];
        endcase
    end
endmodule

// File: rtl/qdac_regport.sv
module qdac_regport
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     srst,
    input  logic                     wr_en,
    input  logic                     wr_all,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic                     wr_kind,
    input  logic [1:0]               part_sel,
    input  logic                     byte_mode,
    input  logic [CODE_W-1:0]        wr_data,
    input  logic                     upd_now,
    input  logic                     xfer,
    input  logic                     transp,
    input  logic [CH_W-1:0]          rd_ch,
    input  logic                     rd_kind,
    input  logic                     rd_rank,
    output logic [CODE_W-1:0]        rd_data,
    output logic [NUM_CH*CODE_W-1:0] code_o,
    output logic [NUM_CH*MODE_W-1:0] mode_o
);
    code_t            code1 [NUM_CH];
    code_t            code2 [NUM_CH];
    mode_t            mode1 [NUM_CH];
    mode_t            mode2 [NUM_CH];
    logic [NUM_CH-1:0] sel;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign sel[i] = wr_all || (wr_ch == i[CH_W-1:0]);

        qdac_chan u_chan (
            .clk      (clk),
            .srst     (srst),
            .sel_i    (sel[i]),
            .wr_i     (wr_en),
            .kind_i   (wr_kind),
            .part_i   (part_sel),
            .byte_i   (byte_mode),
            .din_i    (wr_data),
            .upd_i    (upd_now),
            .xfer_i   (xfer),
            .transp_i (transp),
            .code1_o  (code1[i]),
            .code2_o  (code2[i]),
            .mode1_o  (mode1[i]),
            .mode2_o  (mode2[i])
        );

        assign code_o[i*CODE_W +: CODE_W] = code2[i];
        assign mode_o[i*MODE_W +: MODE_W] = mode2[i];
    end

    qdac_rdmux #(.NUM_CH(NUM_CH)) u_rd (
        .code1_i (code1),
        .code2_i (code2),
        .mode1_i (mode1),
        .mode2_i (mode2),
        .ch_i    (rd_ch),
        .kind_i  (rd_kind),
        .rank_i  (rd_rank),
        .data_o  (rd_data)
    );

    // R3: a single-channel write selects exactly one channel
    a_r3_one_target: assert property (@(posedge clk) disable iff (srst)
        (wr_en && !wr_all) |-> $onehot0(sel) && (sel != '0));
endmodule

// File: tb/sim_qdac_regport.sv
module sim_qdac_regport;
    logic        clk = 1'b0;
    logic        srst = 1'b1;
    logic        wr_en = 0, wr_all = 0, wr_kind = 0, byte_mode = 0;
    logic        upd_now = 0, xfer = 0, transp = 0, rd_kind = 0, rd_rank = 0;
    logic [1:0]  wr_ch = 0, part_sel = 0, rd_ch = 0;
    logic [11:0] wr_data = 0;
    logic [11:0] rd_data;
    logic [47:0] code_o;
    logic [7:0]  mode_o;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    qdac_regport u0 (.*);

    typedef struct packed {
        logic        wr, all;
        logic [1:0]  ch;
        logic        kind;
        logic [1:0]  part;
        logic        byt;
        logic [11:0] din;
        logic        upd, xf, tr;
        logic [1:0]  rch;
        logic        rk, rr;
        logic [11:0] erd;
        logic [47:0] ecode;
        logic [7:0]  emode;
        logic [31:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1,0,0,0,3,0,12'hABC,0,0,0, 0,0,0, 12'hABC, 48'h000_000_000_000, 8'h00, "R3"},
        '{0,0,0,0,0,0,12'h000,0,1,0, 0,0,1, 12'hABC, 48'h000_000_000_ABC, 8'h00, "R5"},
        '{1,0,1,0,0,0,12'h005,1,0,0, 1,0,1, 12'h005, 48'h000_000_005_ABC, 8'h00, "R8"},
        '{1,0,1,0,1,0,12'h007,1,0,0, 1,0,0, 12'h075, 48'h000_000_075_ABC, 8'h00, "R8"},
        '{1,0,1,0,2,0,12'h009,1,0,0, 1,0,1, 12'h975, 48'h000_000_975_ABC, 8'h00, "R4"},
        '{1,0,1,0,0,1,12'h03C,1,0,0, 1,0,1, 12'h93C, 48'h000_000_93C_ABC, 8'h00, "R9"},
        '{1,0,1,0,1,1,12'h0EE,1,0,0, 1,0,1, 12'hEEC, 48'h000_000_EEC_ABC, 8'h00, "R9"},
        '{1,0,1,0,2,1,12'h00F,1,0,0, 1,0,1, 12'hFEC, 48'h000_000_FEC_ABC, 8'h00, "R9"},
        '{1,0,2,1,0,0,12'h003,0,0,0, 2,1,0, 12'h003, 48'h000_000_FEC_ABC, 8'h00, "R2"},
        '{1,1,0,0,3,0,12'h123,0,0,0, 3,0,0, 12'h123, 48'h000_000_FEC_ABC, 8'h00, "R3"},
        '{0,0,0,0,0,0,12'h000,0,1,0, 2,1,1, 12'h003, 48'h123_123_123_123, 8'h30, "R5"},
        '{0,0,0,0,0,0,12'hFFF,0,0,1, 0,0,0, 12'hFFF, 48'h123_123_123_FFF, 8'h30, "R6"},
        '{0,1,0,0,0,0,12'h456,0,0,1, 3,0,1, 12'h456, 48'h456_456_456_456, 8'h30, "R6"},
        '{1,0,3,1,0,0,12'h001,1,0,0, 3,1,0, 12'h001, 48'h456_456_456_456, 8'h70, "R2"},
        '{1,0,0,0,3,0,12'h800,0,1,0, 0,0,1, 12'h800, 48'h456_456_456_800, 8'h70, "R5"},
        '{1,0,0,1,0,0,12'h002,0,0,0, 0,1,0, 12'h002, 48'h456_456_456_800, 8'h70, "R2"},
        '{1,0,1,0,0,0,12'h00A,1,0,0, 1,0,1, 12'h45A, 48'h456_456_45A_800, 8'h70, "R4"}
    };

    task automatic check(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_all = 0; wr_ch = 0; wr_kind = 0; part_sel = 0; byte_mode = 0;
        wr_data = 0; upd_now = 0; xfer = 0; transp = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle();
        repeat (2) @(posedge clk);
        #2;
        check("R10", "reset code_o", code_o, 48'h0);
        check("R10", "reset mode_o", {40'h0, mode_o}, 48'h0);
        check("R7",  "reset readback", {36'h0, rd_data}, 48'h0);
        srst = 0;

        for (int v = 0; v < NV; v++) begin
            wr_en = TBL[v].wr; wr_all = TBL[v].all; wr_ch = TBL[v].ch;
            wr_kind = TBL[v].kind; part_sel = TBL[v].part; byte_mode = TBL[v].byt;
            wr_data = TBL[v].din; upd_now = TBL[v].upd; xfer = TBL[v].xf;
            transp = TBL[v].tr; rd_ch = TBL[v].rch; rd_kind = TBL[v].rk; rd_rank = TBL[v].rr;
            @(posedge clk);
            #2;
            check(string'(TBL[v].req[15:0]), $sformatf("vec%0d code_o R1", v), code_o, TBL[v].ecode);
            check(string'(TBL[v].req[15:0]), $sformatf("vec%0d mode_o", v), {40'h0, mode_o}, {40'h0, TBL[v].emode});
            check("R7", $sformatf("vec%0d rd_data", v), {36'h0, rd_data}, {36'h0, TBL[v].erd});
        end

        // R10: clear overrides a simultaneous write and transfer
        idle();
        srst = 1; wr_en = 1; wr_kind = 0; part_sel = 3; wr_data = 12'h777; xfer = 1;
        @(posedge clk);
        #2;
        srst = 0; idle();
        rd_ch = 0; rd_kind = 1; rd_rank = 0;
        @(posedge clk);
        #2;
        check("R10", "clear code_o", code_o, 48'h0);
        check("R10", "clear mode_o", {40'h0, mode_o}, 48'h0);
        check("R10", "clear staging mode ch0", {36'h0, rd_data}, 48'h0);
        xfer = 1;
        @(posedge clk);
        #2;
        xfer = 0;
        check("R10", "transfer after clear", code_o, 48'h0);

        // R6: transparent load wins over a simultaneous write on the same channel
        transp = 1; wr_en = 1; wr_ch = 2; wr_kind = 0; part_sel = 3; wr_data = 12'h5A5;
        rd_ch = 2; rd_kind = 0; rd_rank = 1;
        @(posedge clk);
        #2;
        idle();
        check("R6", "transparent ch2 code_o", code_o, 48'h000_5A5_000_000);
        check("R6", "transparent ch2 live read", {36'h0, rd_data}, {36'h0, 12'h5A5});

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule